// File: doc/BRIEF.md
# Audio Dual Rate Clock Generator

This block derives two audio master clocks from four input clock sources. One generator serves the 44.1 kHz sample-rate family and the other serves the 48 kHz family. Inside the system clock domain every input clock arrives as a one-cycle enable tick. Each generator counts the ticks of the input it has selected and emits one enable pulse per division period. It also drives a half-duty level for the divided clock. A control bit chooses which of the two generators drives the external output clock.

A small register interface holds four things: the control word, one 10-bit divider word per generator, and the per-port clock-select fields. The select fields route an input clock tick or a generator pulse to each of nine serial audio ports. Port 8 has no field of its own and always copies port 7. A divider word written in the middle of a period waits until the current period ends before it is used, so a reprogram never produces a shortened period.

Register addresses: 0 is the control word, 1 is generator A's divider word, 2 is generator B's divider word, 3 holds the selects for ports 0 to 3, and 4 holds the selects for ports 4 to 7. Reads are combinational on `addr_i`.

Top module: `aclk_rate_gen`

## Requirements
- R1: After reset the control word and both port-select registers read 0, both divider words read 2, and every tick output is low.
- R2: A divider word keeps bits 9:0 only: bits 9:8 are an exponent e and bits 7:0 are n. Its bits 31:10 read 0. While the selected input ticks every cycle, the generator emits a one-cycle pulse every (2 << 2e)*(n+1) cycles.
- R3: With the reset divider word 2, each generator divides its input by 6.
- R4: The divided clock level is high for exactly half of the input ticks of each period. `out_clk_o` carries this level.
- R5: Control bits 22:20 select generator A's input and bits 18:16 select generator B's input. The codes are 0 = input A, 1 = input B, 4 = input C and 2 = input I (`src_tick_i` bits 0, 1, 2, 3). Any other code feeds no ticks, and that generator emits no pulse.
- R6: When control bit 31 is set, `out_tick_o` and `out_clk_o` follow generator B. When it is clear they follow generator A.
- R7: Only control bits 31, 22:20 and 18:16 can be written (mask 0x80770000). All other control bits read 0.
- R8: A divider word written during a period takes effect only after that period ends. The current period keeps its old length.
- R9: Port k (0 to 7) takes its 8-bit select code from bits (k mod 4)*8+7 : (k mod 4)*8 of register 3 (ports 0 to 3) or register 4 (ports 4 to 7). Codes 0x01, 0x02, 0x03 and 0x00 pick inputs A, B, C and I. A port tick appears one cycle after the source tick.
- R10: A select code other than 0x00, 0x01, 0x02, 0x03, 0x10 or 0x20 stops the port: it never ticks.
- R11: Port 8 ticks exactly when port 7 ticks.
- R12: Code 0x10 routes generator A's pulse to a port and code 0x20 routes generator B's pulse. The port ticks one cycle after the generator pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_tick_i | input | 4 | Input clock ticks: bit0 A, bit1 B, bit2 C, bit3 I |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address, used for both reads and writes |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data at `addr_i` |
| gen_a_tick_o | output | 1 | Generator A period pulse |
| gen_b_tick_o | output | 1 | Generator B period pulse |
| out_tick_o | output | 1 | Pulse of the generator chosen by control bit 31 |
| out_clk_o | output | 1 | Divided clock level of the chosen generator |
| port_tick_o | output | 9 | Clock ticks for serial ports 0 to 8 |

## Verification
Each generator's count and its active divider word are visible only through the spacing of its pulses and the duty of its level. A corrupted count therefore shows up as a wrong interval within one period of the affected generator. A word loaded at the wrong moment shows up as one wrong-length period straight after a mid-period write. A wrong decode of an input or port select shows up in the very next cycle after a source tick: a port ticks that should stay silent, or stays silent when it should tick. Wrong generator decodes show up as missing pulses. The bench measures whole periods between pulses. It also compares the complete nine-bit port vector one cycle after each single-source tick.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  localparam int N_SRC       = 4;
  localparam int N_GEN       = 2;
  localparam int N_PORT      = 9;
  localparam int N_PORT_SEL  = N_PORT - 1;
  localparam int SEL_W       = 8;
  localparam int REG_W       = 32;
  localparam int FLD_PER_REG = REG_W / SEL_W;
  localparam int N_SELREG    = (N_PORT_SEL + FLD_PER_REG - 1) / FLD_PER_REG;
  localparam int ADDR_W      = 3;
  localparam int DIV_W       = 10;
  localparam int EXP_W       = 2;
  localparam int MANT_W      = DIV_W - EXP_W;
  localparam int CNT_W       = MANT_W + 2 * ((1 << EXP_W) - 1) + 2;
  localparam int GSEL_W      = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIV0  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_PSEL0 = 3'd3;

  localparam logic [REG_W-1:0] CTRL_MASK = 32'h8077_0000;
  localparam int               OUT_SEL_BIT = 31;
  localparam int               GEN_SEL_LSB [N_GEN] = '{20, 16};
  localparam logic [DIV_W-1:0] DIV_RST = 10'd2;

  // generator input select: 0=A 1=B 4=C 2=I
  function automatic logic [N_SRC-1:0] gen_src_mask(input logic [GSEL_W-1:0] code);
    case (code)
      3'd0:    return 4'b0001;
      3'd1:    return 4'b0010;
      3'd4:    return 4'b0100;
      3'd2:    return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic port_hit(input logic [SEL_W-1:0] code,
                                    input logic [N_SRC-1:0] src,
                                    input logic ga, input logic gb);
    case (code)
      8'h00:   return src[3];
      8'h01:   return src[0];
      8'h02:   return src[1];
      8'h03:   return src[2];
      8'h10:   return ga;
      8'h20:   return gb;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/aclk_regs.sv
module aclk_regs
  import aclk_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [REG_W-1:0]            wr_data_i,
  output logic                        out_sel_o,
  output logic [N_GEN*GSEL_W-1:0]     gen_sel_o,
  output logic [N_GEN*DIV_W-1:0]      div_word_o,
  output logic [N_SELREG*REG_W-1:0]   psel_o,
  output logic [REG_W-1:0]            rd_data_o
);
  logic [REG_W-1:0] ctrl_q;
  logic [DIV_W-1:0] div_q  [N_GEN];
  logic [REG_W-1:0] psel_q [N_SELREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_en_i && addr_i == ADDR_CTRL) ctrl_q <= wr_data_i & CTRL_MASK;
  end

  for (genvar g = 0; g < N_GEN; g++) begin : g_div
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) div_q[g] <= DIV_RST;
      else if (wr_en_i && addr_i == ADDR_W'(ADDR_DIV0 + g)) div_q[g] <= wr_data_i[DIV_W-1:0];
    end
    assign div_word_o[g*DIV_W +: DIV_W]   = div_q[g];
    assign gen_sel_o[g*GSEL_W +: GSEL_W] = ctrl_q[GEN_SEL_LSB[g] +: GSEL_W];
  end

  for (genvar r = 0; r < N_SELREG; r++) begin : g_psel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) psel_q[r] <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(ADDR_PSEL0 + r)) psel_q[r] <= wr_data_i;
    end
    assign psel_o[r*REG_W +: REG_W] = psel_q[r];
  end

  assign out_sel_o = ctrl_q[OUT_SEL_BIT];

  always_comb begin
    rd_data_o = '0;
    if (addr_i == ADDR_CTRL) rd_data_o = ctrl_q;
    for (int g = 0; g < N_GEN; g++)
      if (addr_i == ADDR_W'(ADDR_DIV0 + g)) rd_data_o = REG_W'(div_q[g]);
    for (int r = 0; r < N_SELREG; r++)
      if (addr_i == ADDR_W'(ADDR_PSEL0 + r)) rd_data_o = psel_q[r];
  end
endmodule

// File: rtl/aclk_div.sv
module aclk_div
  import aclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] word_i,
  output logic             pulse_o,
  output logic             level_o
);
  logic [DIV_W-1:0]   word_q;
  logic [CNT_W-1:0]   cnt_q, mant_p1, ratio, last, half;
  logic [EXP_W:0]     shamt;

  // ratio = (2 << 2e) * (n+1)
  assign mant_p1 = CNT_W'(word_q[MANT_W-1:0]) + CNT_W'(1);
  assign shamt   = {word_q[DIV_W-1 -: EXP_W], 1'b1};
  assign ratio   = mant_p1 << shamt;
  assign last    = ratio - CNT_W'(1);
  assign half    = ratio >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= DIV_RST;
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (tick_i) begin
        if (cnt_q >= last) begin
          cnt_q   <= '0;
          word_q  <= word_i;   // new word only at period end
          pulse_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign level_o = (cnt_q < half);
endmodule

// File: rtl/aclk_port_mux.sv
module aclk_port_mux
  import aclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] code_i,
  input  logic [N_SRC-1:0] src_tick_i,
  input  logic             gen_a_i,
  input  logic             gen_b_i,
  output logic             tick_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_o <= 1'b0;
    else         tick_o <= port_hit(code_i, src_tick_i, gen_a_i, gen_b_i);
  end
endmodule

// File: rtl/aclk_rate_gen.sv
module aclk_rate_gen
  import aclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              gen_a_tick_o,
  output logic              gen_b_tick_o,
  output logic              out_tick_o,
  output logic              out_clk_o,
  output logic [N_PORT-1:0] port_tick_o
);
  logic                      out_sel;
  logic [N_GEN*GSEL_W-1:0]   gen_sel;
  logic [N_GEN*DIV_W-1:0]    div_word;
  logic [N_SELREG*REG_W-1:0] psel;
  logic [N_GEN-1:0]          gen_tick, gen_pulse, gen_level;

  aclk_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wr_data_i  (wr_data_i),
    .out_sel_o  (out_sel),
    .gen_sel_o  (gen_sel),
    .div_word_o (div_word),
    .psel_o     (psel),
    .rd_data_o  (rd_data_o)
  );

  for (genvar g = 0; g < N_GEN; g++) begin : g_gen
    assign gen_tick[g] = |(gen_src_mask(gen_sel[g*GSEL_W +: GSEL_W]) & src_tick_i);
    aclk_div u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (gen_tick[g]),
      .word_i  (div_word[g*DIV_W +: DIV_W]),
      .pulse_o (gen_pulse[g]),
      .level_o (gen_level[g])
    );
  end

  assign gen_a_tick_o = gen_pulse[0];
  assign gen_b_tick_o = gen_pulse[1];
  assign out_tick_o   = out_sel ? gen_pulse[1] : gen_pulse[0];
  assign out_clk_o    = out_sel ? gen_level[1] : gen_level[0];

  for (genvar p = 0; p < N_PORT_SEL; p++) begin : g_port
    aclk_port_mux u_mux (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .code_i     (psel[p*SEL_W +: SEL_W]),
      .src_tick_i (src_tick_i),
      .gen_a_i    (gen_pulse[0]),
      .gen_b_i    (gen_pulse[1]),
      .tick_o     (port_tick_o[p])
    );
  end
  // last port has no field and shares its neighbour's clock
  assign port_tick_o[N_PORT-1] = port_tick_o[N_PORT-2];
endmodule

// File: rtl/aclk_rate_gen_chk.sv
module aclk_rate_gen_chk
  import aclk_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  src_tick_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  rd_data_o,
  input logic              gen_a_tick_o,
  input logic              gen_b_tick_o,
  input logic [N_PORT-1:0] port_tick_o
);
  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_CTRL) |-> ((rd_data_o & ~CTRL_MASK) == '0)); // R7

  AST_DIVW_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_DIV0 || addr_i == ADDR_W'(ADDR_DIV0 + 1)) |-> (rd_data_o[REG_W-1:DIV_W] == '0)); // R2

  AST_GEN_A_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_a_tick_o |=> !gen_a_tick_o); // R2

  AST_GEN_B_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_b_tick_o |=> !gen_b_tick_o); // R2

  AST_GEN_NEEDS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_a_tick_o || gen_b_tick_o) |-> $past(|src_tick_i)); // R5

  AST_LAST_PORT_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_tick_o[N_PORT-1] == port_tick_o[N_PORT-2]); // R11

  AST_PORT_NEEDS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|port_tick_o) |-> $past((|src_tick_i) || gen_a_tick_o || gen_b_tick_o)); // R9
endmodule

bind aclk_rate_gen aclk_rate_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .src_tick_i   (src_tick_i),
  .addr_i       (addr_i),
  .rd_data_o    (rd_data_o),
  .gen_a_tick_o (gen_a_tick_o),
  .gen_b_tick_o (gen_b_tick_o),
  .port_tick_o  (port_tick_o)
);

// File: tb/aclk_rate_gen_tb.sv
module aclk_rate_gen_tb;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ga, gb, ot, oc;
  logic [8:0]  ptick;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  aclk_rate_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src), .wr_en_i(wr_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata),
    .gen_a_tick_o(ga), .gen_b_tick_o(gb), .out_tick_o(ot), .out_clk_o(oc),
    .port_tick_o(ptick)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic [9:0]  word;
    logic [3:0]  src;
    logic [15:0] ratio;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd0, 10'h002, 4'b0001, 16'd6},
    '{3'd1, 10'h000, 4'b0010, 16'd2},
    '{3'd4, 10'h105, 4'b0100, 16'd48},
    '{3'd2, 10'h203, 4'b1000, 16'd128},
    '{3'd0, 10'h0FF, 4'b0001, 16'd512},
    '{3'd1, 10'h301, 4'b0010, 16'd256}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic sig(input int w);
    case (w)
      0:       return ga;
      1:       return gb;
      default: return ot;
    endcase
  endfunction

  task automatic wait_sig(input int w, input int limit, output int cyc, output bit found);
    cyc = 0; found = 0;
    while (!found && cyc < limit) begin
      @(negedge clk);
      cyc++;
      found = sig(w);
    end
  endtask

  // called at a pulse; returns cycles to the next pulse and level-high cycles in between
  task automatic measure(input int w, output int per, output int hi);
    hi = int'(oc); per = 0;
    do begin
      @(negedge clk);
      per++;
      if (!sig(w)) hi += int'(oc);
    end while (!sig(w) && per < 70000);
  endtask

  task automatic sync2(input int w);
    int c; bit f;
    wait_sig(w, 70000, c, f);
    wait_sig(w, 70000, c, f);
    chk(f, "R2", "pulse seen", int'(f), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int per, hi, c;
    bit f;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, d); chk(d == 0, "R1", "ctrl reset", d, 0);
    rd(3'd1, d); chk(d == 2, "R1", "div A reset", d, 2);
    rd(3'd2, d); chk(d == 2, "R1", "div B reset", d, 2);
    rd(3'd3, d); chk(d == 0, "R1", "psel lo reset", d, 0);
    rd(3'd4, d); chk(d == 0, "R1", "psel hi reset", d, 0);
    chk({ga, gb, ot, ptick} == 0, "R1", "ticks low", {ga, gb, ot, ptick}, 0);

    // R3 default ratio 6 on both generators (both select input A at reset)
    src = 4'b0001;
    sync2(0); measure(0, per, hi);
    chk(per == 6, "R3", "gen A default period", per, 6);
    chk(hi == 3, "R4", "gen A default high", hi, 3);
    sync2(1); measure(1, per, hi);
    chk(per == 6, "R3", "gen B default period", per, 6);

    // R2 R4 R5 table of ratios and input selects
    for (int i = 0; i < 6; i++) begin
      wr(3'd0, 32'(VECS[i].sel) << 20);
      wr(3'd1, 32'(VECS[i].word));
      src = VECS[i].src;
      sync2(0);
      measure(0, per, hi);
      chk(per == int'(VECS[i].ratio), "R2", $sformatf("vec %0d period", i), per, int'(VECS[i].ratio));
      chk(hi == int'(VECS[i].ratio) / 2, "R4", $sformatf("vec %0d high", i), hi, int'(VECS[i].ratio) / 2);
      rd(3'd1, d);
      chk(d == 32'(VECS[i].word), "R2", $sformatf("vec %0d word readback", i), d, 32'(VECS[i].word));
    end

    // R8 mid-period rewrite keeps the running period
    wr(3'd0, 32'h0);
    src = 4'b0001;
    wr(3'd1, 32'h300);
    sync2(0);
    wr(3'd1, 32'h000);
    wait_sig(0, 70000, c, f);
    chk(c + 1 == 128, "R8", "period after mid write", c + 1, 128);
    measure(0, per, hi);
    chk(per == 2, "R8", "new word period", per, 2);

    // R6 output follows generator chosen by bit 31
    wr(3'd2, 32'h001);
    wr(3'd0, 32'h8001_0000);
    src = 4'b0011;
    sync2(2); measure(2, per, hi);
    chk(per == 4, "R6", "out from gen B period", per, 4);
    chk(hi == 2, "R6", "out from gen B high", hi, 2);
    wr(3'd0, 32'h0001_0000);
    sync2(2); measure(2, per, hi);
    chk(per == 2, "R6", "out from gen A period", per, 2);

    // R7 control mask, R2 word width
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); chk(d == 32'h8077_0000, "R7", "ctrl mask", d, 32'h8077_0000);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); chk(d == 32'h3FF, "R2", "div word width", d, 32'h3FF);
    wr(3'd1, 32'h000);
    // R5 undefined select code 7 stops both generators
    src = 4'b1111;
    repeat (3) @(negedge clk);
    c = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      c += int'(ga) + int'(gb);
    end
    chk(c == 0, "R5", "undefined gen select pulses", c, 0);

    // R9 R10 R11 port select decode
    src = 4'b0000;
    wr(3'd0, 32'h0033_0000);
    wr(3'd3, 32'h5510_0301);
    wr(3'd4, 32'h0200_0000);
    repeat (3) @(negedge clk);
    rd(3'd3, d); chk(d == 32'h5510_0301, "R9", "psel lo readback", d, 32'h5510_0301);
    begin
      logic [3:0] pat [5] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b1111};
      logic [8:0] exp [5] = '{9'h001, 9'h180, 9'h002, 9'h070, 9'h1F3};
      for (int k = 0; k < 5; k++) begin
        chk(ptick == 0, "R9", $sformatf("port idle before %0d", k), ptick, 0);
        src = pat[k];
        @(negedge clk);
        src = 4'b0000;
        chk(ptick == exp[k], "R10", $sformatf("port vector pattern %0d (R9 R11)", k), ptick, exp[k]);
        @(negedge clk);
      end
    end

    // R12 generator A routed to port 2 one cycle later
    wr(3'd0, 32'h0);
    src = 4'b0001;
    repeat (4) @(negedge clk);
    wait_sig(0, 1000, c, f);
    chk(f && !ptick[2], "R12", "port 2 at gen pulse", int'(ptick[2]), 0);
    @(negedge clk);
    chk(ptick[2] == 1'b1, "R12", "port 2 after gen pulse", int'(ptick[2]), 1);
    chk(ptick[3] == 1'b0, "R10", "port 3 stopped", int'(ptick[3]), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule